// File: doc/BRIEF.md
# Addend-Tuned Precision Time Counter

This block keeps a free-running 64-bit time-of-day value for a precision time protocol clock. Time is counted in ticks of 32 ns, so software converts nanoseconds to ticks with a 5-bit right shift. The tick rate is set by a 32-bit addend. Every reference clock adds the addend into a 32-bit fractional accumulator, and each carry out of that accumulator advances the time by one tick. The nominal addend is 0xA0000000. Software trims the frequency by writing nominal ± nominal×ppb/1e9, for a range of up to ±50,000,000 ppb.

Software reaches the block through a small 32-bit register port. Through it, software writes the addend, loads and reads the time as two words, opens the rollover limit of the low time word, and issues a soft reset. The low word rolls over at a programmable maximum. The count runs over the full 64 bits only after software writes all ones to that maximum. Time writes and time reads are both done as low word first, then high word. The pairing logic makes each two-word access coherent.

Top module: `ptp_tod_counter`

## Requirements
- R1: After rst_ni is released, the time is 0, the soft reset bit is 0, the addend reads 0xA0000000, the limit enable reads 0, and the low-word maximum reads the parameter LO_MAX_RST (default 0x0FFFFFFF).
- R2: Every cycle the accumulator adds the addend modulo 2^32. A carry out advances the time by exactly one tick at that clock edge, and tick_o is high in that cycle. A cycle with no carry and no time load leaves the time unchanged.
- R3: A write to the addend (offset 1) is used for accumulation from the next cycle on. The accumulated fraction is kept across addend writes and across time loads.
- R4: A write to the low time word (offset 2) goes only into a shadow register and leaves the running time unchanged. A write to the high word (offset 3) loads {written value, shadow} as the new time at that edge, and this load takes precedence over a tick in the same cycle.
- R5: When a tick occurs while the low word is greater than or equal to the low-word maximum, the low word becomes 0 and the high word increments. Otherwise a tick increments the low word.
- R6: A write to the maximum (offset 5) is applied only while bit 0 of the enable register (offset 4) is 1. Otherwise the write is ignored. Both registers read back their values.
- R7: A read of the low word (reg_re_i, offset 2) returns the current low word and captures the current high word. Reads of offset 3 return that captured value.
- R8: While bit 0 of the control register (offset 0) is 1, every register other than control is held at its R1 value and writes to those registers are ignored. Counting resumes from 0 once the bit is written back to 0.
- R9: Register offsets are 0 control, 1 addend, 2 low time, 3 high time, 4 limit enable and 5 maximum. Offsets 6 and 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (needed for the high-word capture) |
| reg_addr_i | input | 3 | Register word offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data for reg_addr_i |
| time_o | output | 64 | Current time in ticks |
| tick_o | output | 1 | High in cycles where the time advances by a tick |

## Verification
Random addends across the full 32-bit range are mixed with addends near the nominal value. This separates a correct carry-based tick from a model that steps the time every cycle or at a fixed rate. Low-word maxima are drawn both small and random, and low-word values are loaded both below and above the maximum. This exposes a rollover test that uses equality where greater-or-equal is required, and it exposes a high word that fails to carry. Back-to-back reads of the low and then the high word, taken while ticks are landing, show whether the captured high word matches the low word it was read with. Maximum writes issued with the enable both open and closed, and rare soft resets, check the write gating and the hold behaviour.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL   = 3'd0,
    REG_ADDEND = 3'd1,
    REG_TLO    = 3'd2,
    REG_THI    = 3'd3,
    REG_MAXEN  = 3'd4,
    REG_MAX    = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/ptp_frac_acc.sv
module ptp_frac_acc #(
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [ACC_W-1:0] addend_i,
  output logic             tick_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  assign sum    = {1'b0, acc_q} + {1'b0, addend_i};
  assign tick_o = sum[ACC_W] & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else             acc_q <= sum[ACC_W-1:0];
  end

  // R8: soft reset empties the fraction
  a_r8_acc_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (acc_q == '0));
  // R2: no carry when addend is zero and fraction is zero
  a_r2_zero_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addend_i == '0) |-> !tick_o);
endmodule

// File: rtl/ptp_time_ctr.sv
module ptp_time_ctr #(
  parameter int unsigned LO_W = 32,
  parameter int unsigned HI_W = 32,
  localparam int unsigned TIME_W = LO_W + HI_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [TIME_W-1:0] load_val_i,
  input  logic [LO_W-1:0]   max_lo_i,
  output logic [TIME_W-1:0] time_o
);
  logic [LO_W-1:0] lo_q;
  logic [HI_W-1:0] hi_q;
  logic            wrap;

  assign wrap   = (lo_q >= max_lo_i);
  assign time_o = {hi_q, lo_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (clr_i) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (load_i) begin
      {hi_q, lo_q} <= load_val_i;
    end else if (tick_i) begin
      if (wrap) begin
        lo_q <= '0;
        hi_q <= hi_q + 1'b1;
      end else begin
        lo_q <= lo_q + 1'b1;
      end
    end
  end

  a_r3_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i && !clr_i) |=> $stable(time_o));
  a_r5_wrap_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && !clr_i && (lo_q >= max_lo_i)) |=> (lo_q == '0));
  a_r8_time_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (time_o == '0));
  a_r4_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i) |=> (time_o == $past(load_val_i)));
endmodule

// File: rtl/ptp_tod_csr.sv
module ptp_tod_csr
  import ptp_tod_pkg::*;
#(
  parameter int unsigned   LO_W       = 32,
  parameter int unsigned   HI_W       = 32,
  parameter logic [31:0]   ADDEND_RST = 32'hA000_0000,
  parameter logic [31:0]   LO_MAX_RST = 32'h0FFF_FFFF,
  localparam int unsigned  TIME_W     = LO_W + HI_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic [TIME_W-1:0] time_i,
  output logic              soft_rst_o,
  output logic [REG_W-1:0]  addend_o,
  output logic              load_o,
  output logic [TIME_W-1:0] load_val_o,
  output logic [LO_W-1:0]   max_lo_o
);
  logic            ctrl_q;
  logic [REG_W-1:0] addend_q;
  logic [LO_W-1:0] shadow_q;
  logic            max_en_q;
  logic [LO_W-1:0] max_q;
  logic [HI_W-1:0] snap_q;

  assign soft_rst_o = ctrl_q;
  assign addend_o   = addend_q;
  assign max_lo_o   = max_q;
  assign load_o     = we_i && (addr_i == REG_THI) && !ctrl_q;
  assign load_val_o = {wdata_i[HI_W-1:0], shadow_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= 1'b0;
    else if (we_i && addr_i == REG_CTRL) ctrl_q <= wdata_i[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni || ctrl_q) begin
      addend_q <= ADDEND_RST;
      shadow_q <= '0;
      max_en_q <= 1'b0;
      max_q    <= LO_MAX_RST[LO_W-1:0];
      snap_q   <= '0;
    end else begin
      if (we_i) begin
        case (addr_i)
          REG_ADDEND: addend_q <= wdata_i;
          REG_TLO:    shadow_q <= wdata_i[LO_W-1:0];
          REG_MAXEN:  max_en_q <= wdata_i[0];
          REG_MAX:    if (max_en_q) max_q <= wdata_i[LO_W-1:0];
          default: ;
        endcase
      end
      if (re_i && addr_i == REG_TLO) snap_q <= time_i[TIME_W-1:LO_W];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_CTRL:   rdata_o[0]        = ctrl_q;
      REG_ADDEND: rdata_o           = addend_q;
      REG_TLO:    rdata_o[LO_W-1:0] = time_i[LO_W-1:0];
      REG_THI:    rdata_o[HI_W-1:0] = snap_q;
      REG_MAXEN:  rdata_o[0]        = max_en_q;
      REG_MAX:    rdata_o[LO_W-1:0] = max_q;
      default:    rdata_o           = '0;
    endcase
  end

  a_r6_max_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!max_en_q && !ctrl_q) |=> $stable(max_q));
  a_r7_snap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == REG_TLO && !ctrl_q) |=> (snap_q == $past(time_i[TIME_W-1:LO_W])));
  a_r8_addend_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q |=> (addend_q == ADDEND_RST));
endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter #(
  parameter logic [31:0] ADDEND_RST = 32'hA000_0000,
  parameter logic [31:0] LO_MAX_RST = 32'h0FFF_FFFF,
  parameter int unsigned LO_W       = 32,
  parameter int unsigned HI_W       = 32,
  localparam int unsigned TIME_W    = LO_W + HI_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic [TIME_W-1:0] time_o,
  output logic              tick_o
);
  logic              soft_rst;
  logic [31:0]       addend;
  logic              load;
  logic [TIME_W-1:0] load_val;
  logic [LO_W-1:0]   max_lo;
  logic              tick;

  assign tick_o = tick;

  ptp_tod_csr #(
    .LO_W(LO_W), .HI_W(HI_W), .ADDEND_RST(ADDEND_RST), .LO_MAX_RST(LO_MAX_RST)
  ) u_csr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(reg_we_i), .re_i(reg_re_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .time_i(time_o), .soft_rst_o(soft_rst), .addend_o(addend),
    .load_o(load), .load_val_o(load_val), .max_lo_o(max_lo)
  );

  ptp_frac_acc #(.ACC_W(32)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(soft_rst),
    .addend_i(addend), .tick_o(tick)
  );

  ptp_time_ctr #(.LO_W(LO_W), .HI_W(HI_W)) u_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(soft_rst),
    .tick_i(tick), .load_i(load), .load_val_i(load_val),
    .max_lo_i(max_lo), .time_o(time_o)
  );

  // R2: a tick never coexists with soft reset
  a_r2_tick_not_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |-> !tick_o);
endmodule

// File: tb/ptp_tod_counter_tb.sv
module ptp_tod_counter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] NOM = 32'hA000_0000;
  localparam logic [31:0] MAXR = 32'h0FFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] time_v;
  logic        tick;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptp_tod_counter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .time_o(time_v), .tick_o(tick)
  );

  // reference state built from the requirements
  logic        m_ctrl, m_en;
  logic [31:0] m_add, m_acc, m_shadow, m_max, m_snap;
  logic [63:0] m_time;

  function automatic logic [63:0] next_time(logic [63:0] t, logic [31:0] mx);
    if (t[31:0] >= mx) return {t[63:32] + 32'd1, 32'd0};
    return {t[63:32], t[31:0] + 32'd1};
  endfunction

  function automatic logic [31:0] m_read(logic [2:0] a);
    case (a)
      3'd0: return {31'd0, m_ctrl};
      3'd1: return m_add;
      3'd2: return m_time[31:0];
      3'd3: return m_snap;
      3'd4: return {31'd0, m_en};
      3'd5: return m_max;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(logic [2:0] a);
    case (a)
      3'd0: return "R8";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R7";
      3'd4, 3'd5: return "R6";
      default: return "R9";
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl <= 1'b0; m_en <= 1'b0; m_add <= NOM; m_acc <= '0;
      m_shadow <= '0; m_max <= MAXR; m_snap <= '0; m_time <= '0;
    end else begin
      if (we && addr == 3'd0) m_ctrl <= wdata[0];
      if (m_ctrl) begin
        m_en <= 1'b0; m_add <= NOM; m_acc <= '0;
        m_shadow <= '0; m_max <= MAXR; m_snap <= '0; m_time <= '0;
      end else begin
        logic [32:0] s;
        s = {1'b0, m_acc} + {1'b0, m_add};
        m_acc <= s[31:0];
        if (we && addr == 3'd3) m_time <= {wdata, m_shadow};
        else if (s[32]) m_time <= next_time(m_time, m_max);
        if (we && addr == 3'd1) m_add <= wdata;
        if (we && addr == 3'd2) m_shadow <= wdata;
        if (we && addr == 3'd4) m_en <= wdata[0];
        if (we && addr == 3'd5 && m_en) m_max <= wdata;
        if (re && addr == 3'd2) m_snap <= m_time[63:32];
      end
    end
  end

  task automatic check64(string tg, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tg, act, exp);
    end
  endtask

  task automatic step(logic w, logic r, logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    check64("R2 R5 time", time_v, m_time);
    we = w; re = r; addr = a; wdata = d;
    #1;
    if (r) check64(tag_of(a), {32'd0, rdata}, {32'd0, m_read(a)});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state at the ports before the first edge
    check64("R1 time", time_v, 64'd0);
    re = 1'b1; addr = 3'd1; #1; check64("R1 addend", {32'd0, rdata}, {32'd0, NOM});
    addr = 3'd5; #1; check64("R1 max", {32'd0, rdata}, {32'd0, MAXR});
    addr = 3'd0; #1; check64("R1 ctrl", {32'd0, rdata}, 64'd0);
    addr = 3'd4; #1; check64("R1 en", {32'd0, rdata}, 64'd0);
    re = 1'b0;

    // R6: max write ignored while enable closed
    step(1, 0, 3'd5, 32'd7);
    step(0, 1, 3'd5, 0);
    // R5: open the limit to a small value and force wraps
    step(1, 0, 3'd4, 1);
    step(1, 0, 3'd5, 32'd4);
    step(1, 0, 3'd1, 32'hFFFF_FFFF);
    step(1, 0, 3'd2, 32'd2);
    step(1, 0, 3'd3, 32'h0000_0010);
    for (int i = 0; i < 20; i++) step(0, 1, (i % 2) ? 3'd3 : 3'd2, 0);
    // R5: low loaded above the max wraps on next tick
    step(1, 0, 3'd2, 32'd100);
    step(1, 0, 3'd3, 32'd1);
    for (int i = 0; i < 4; i++) step(0, 0, 3'd0, 0);
    // R9: unused offsets read zero
    step(0, 1, 3'd6, 0);
    step(0, 1, 3'd7, 0);
    // open full range, nominal rate
    step(1, 0, 3'd5, 32'hFFFF_FFFF);
    step(1, 0, 3'd1, NOM);
    step(1, 0, 3'd2, 32'hFFFF_FFFE);
    step(1, 0, 3'd3, 32'h0000_0042);
    for (int i = 0; i < 12; i++) step(0, 1, (i % 2) ? 3'd3 : 3'd2, 0);
    // R8: soft reset hold and release
    step(1, 0, 3'd0, 1);
    step(1, 0, 3'd1, 32'h1234_5678);
    step(0, 1, 3'd1, 0);
    step(0, 1, 3'd0, 0);
    step(1, 0, 3'd0, 0);
    for (int i = 0; i < 6; i++) step(0, 1, 3'd2, 0);

    for (int i = 0; i < 6000; i++) begin
      int unsigned op;
      logic [31:0] d;
      op = $urandom % 20;
      d = $urandom;
      case (op)
        0, 1, 2, 3, 4, 5, 6: step(0, 1, 3'($urandom % 8), 0);
        7: step(1, 0, 3'd1, ($urandom % 2) ? d : NOM + (d % 32'h0400_0000) - 32'h0200_0000);
        8: step(1, 0, 3'd2, ($urandom % 2) ? d : (d % 16));
        9: step(1, 0, 3'd3, ($urandom % 2) ? d : (d % 4));
        10: step(1, 0, 3'd4, d % 2);
        11: step(1, 0, 3'd5, ($urandom % 2) ? d : (d % 16));
        12: step(1, 0, 3'd0, (($urandom % 16) == 0) ? 32'd1 : 32'd0);
        13: step(0, 1, 3'd2, 0);
        14: step(0, 1, 3'd3, 0);
        default: step(0, 0, 3'd0, 0);
      endcase
    end
    step(1, 0, 3'd0, 0);
    step(0, 0, 3'd0, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule